// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block is the issue stage of an in-order superscalar core that has two integer pipes. A general pipe, U, takes any instruction. A restricted pipe, V, takes only instructions marked as simple. Each cycle the instruction queue offers its two oldest entries, the lead and the trail. Each entry carries pre-decoded attributes: a valid bit, a simple flag, a flag that says it must occupy both pipes, its source register indices, and a destination index with a write-enable. The pairing decision is made entirely in hardware.

The older entry always goes to U. The trail entry joins it on V only when it is valid and simple, the lead does not claim both pipes, and the trail neither reads nor writes the lead's destination register. An unpaired trail entry is not reordered. It stays in the queue and becomes the lead on a later cycle. A combinational take count (0, 1 or 2) tells the queue how many entries to pop, and it is nonzero only while the downstream ready input is high. Each accepted instruction shows up one cycle later on the registered issue outputs of its pipe.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is asserted, and after reset until a valid lead is offered with ready high, the take count is 0 and both issue-valid outputs are low.
- R2: When ready is low the take count is 0 and neither pipe issues on the following cycle.
- R3: A valid lead with ready high gives a take count of at least 1, and on the next cycle U is valid carrying the lead's payload, whatever the lead's simple flag.
- R4: A trail entry whose simple flag is low is never paired: the take count is 1 and V stays invalid.
- R5: A lead that claims both pipes is never paired: the take count is 1.
- R6: The pair is refused when any source index of the trail equals the lead's destination and the lead's write-enable is high.
- R7: The pair is refused when both write-enables are high and the destinations match. With the lead's write-enable low, no register match blocks pairing.
- R8: An invalid lead gives a take count of 0 and no issue, even when the trail is valid. The trail is never promoted ahead of the lead.
- R9: When every pairing condition holds, the take count is 2, and on the next cycle U carries the lead's payload and V carries the trail's payload.
- R10: V is never valid unless U is valid in the same cycle, and the take count never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Downstream pipes can accept this cycle |
| ld_vld_i | input | 1 | Lead entry valid |
| ld_simple_i | input | 1 | Lead entry is of the simple class |
| ld_both_i | input | 1 | Lead entry needs both pipes |
| ld_src_i | input | NUM_SRC*REG_W | Lead source register indices |
| ld_dst_i | input | REG_W | Lead destination register index |
| ld_wr_i | input | 1 | Lead writes its destination |
| ld_op_i | input | PAYLOAD_W | Lead payload |
| tr_vld_i | input | 1 | Trail entry valid |
| tr_simple_i | input | 1 | Trail entry is of the simple class |
| tr_both_i | input | 1 | Trail entry needs both pipes |
| tr_src_i | input | NUM_SRC*REG_W | Trail source register indices |
| tr_dst_i | input | REG_W | Trail destination register index |
| tr_wr_i | input | 1 | Trail writes its destination |
| tr_op_i | input | PAYLOAD_W | Trail payload |
| take_o | output | 2 | Entries popped from the queue this cycle (0, 1, 2) |
| u_vld_o | output | 1 | U pipe issue valid (registered) |
| u_op_o | output | PAYLOAD_W | U pipe payload |
| v_vld_o | output | 1 | V pipe issue valid (registered) |
| v_op_o | output | PAYLOAD_W | V pipe payload, meaningful only with v_vld_o |

## Verification
The vector table starts from a baseline that pairs and then breaks exactly one pairing condition per row: trail class, lead wide flag, a read match on each source slot in turn, a destination match, ready low and an invalid lead. A difference of 2 against 1 in the take count therefore isolates one rule at a time. Control rows check that a complex lead still issues and pairs, and that a register match without the matching write-enable does not block pairing. A short in-order queue model then pops entries by the reported count, so the issue sequence shows that a refused trail becomes the next lead and is never overtaken.

// File: rtl/pair_pkg.sv
package pair_pkg;

   typedef enum logic [1:0] {
      TAKE_NONE = 2'd0,
      TAKE_ONE  = 2'd1,
      TAKE_TWO  = 2'd2
   } take_e;

   localparam int unsigned PIPES = 2;
   localparam int unsigned PIPE_U = 0;
   localparam int unsigned PIPE_V = 1;

endpackage

// File: rtl/pair_hazard.sv
module pair_hazard #(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned NUM_SRC   = 2,
   parameter bit          CHECK_WAW = 1'b1
) (
   input  logic [REG_W-1:0]         lead_dst,
   input  logic                     lead_wr,
   input  logic [NUM_SRC*REG_W-1:0] trail_src,
   input  logic [REG_W-1:0]         trail_dst,
   input  logic                     trail_wr,
   output logic                     conflict
);

   if (REG_W < 1) begin : g_bad_regw
      $error("pair_hazard: REG_W must be at least 1");
   end
   if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_nsrc
      $error("pair_hazard: NUM_SRC must be 1..4");
   end

   logic [NUM_SRC-1:0] raw_hit;
   logic               waw_hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign raw_hit[s] = lead_wr &&
                          (trail_src[s*REG_W +: REG_W] == lead_dst);
   end

   if (CHECK_WAW) begin : g_waw
      assign waw_hit = lead_wr && trail_wr && (trail_dst == lead_dst);
   end else begin : g_no_waw
      assign waw_hit = 1'b0;
   end

   assign conflict = (|raw_hit) || waw_hit;

endmodule

// File: rtl/pair_rules.sv
module pair_rules
   import pair_pkg::*;
(
   input  logic  rst_n,
   input  logic  ready,
   input  logic  ld_vld,
   input  logic  ld_both,
   input  logic  tr_vld,
   input  logic  tr_simple,
   input  logic  tr_both,
   input  logic  conflict,
   output take_e take,
   output logic  go_u,
   output logic  go_v
);

   logic slot_open;
   logic trail_fits;

   assign slot_open  = rst_n && ready && ld_vld;
   assign trail_fits = tr_vld && tr_simple && !tr_both;

   always_comb begin
      go_u = slot_open;
      go_v = slot_open && trail_fits && !ld_both && !conflict;
      if (go_v)      take = TAKE_TWO;
      else if (go_u) take = TAKE_ONE;
      else           take = TAKE_NONE;
   end

endmodule

// File: rtl/issue_stage.sv
module issue_stage
   import pair_pkg::*;
#(
   parameter int unsigned PAYLOAD_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIPES-1:0]     go,
   input  logic [PAYLOAD_W-1:0] op_in  [PIPES],
   output logic [PIPES-1:0]     vld,
   output logic [PAYLOAD_W-1:0] op_out [PIPES]
);

   if (PAYLOAD_W < 1) begin : g_bad_pw
      $error("issue_stage: PAYLOAD_W must be at least 1");
   end

   for (genvar p = 0; p < PIPES; p++) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[p]    <= 1'b0;
            op_out[p] <= '0;
         end else begin
            vld[p]    <= go[p];
            op_out[p] <= op_in[p];
         end
      end
   end

   // R10: the restricted pipe never runs without the general one
   a_r10_v_needs_u: assert property (@(posedge clk) disable iff (!rst_n)
      vld[PIPE_V] |-> vld[PIPE_U]);

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import pair_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned NUM_SRC   = 2,
   parameter int unsigned PAYLOAD_W = 32,
   parameter bit          CHECK_WAW = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ready_i,
   input  logic                     ld_vld_i,
   input  logic                     ld_simple_i,
   input  logic                     ld_both_i,
   input  logic [NUM_SRC*REG_W-1:0] ld_src_i,
   input  logic [REG_W-1:0]         ld_dst_i,
   input  logic                     ld_wr_i,
   input  logic [PAYLOAD_W-1:0]     ld_op_i,
   input  logic                     tr_vld_i,
   input  logic                     tr_simple_i,
   input  logic                     tr_both_i,
   input  logic [NUM_SRC*REG_W-1:0] tr_src_i,
   input  logic [REG_W-1:0]         tr_dst_i,
   input  logic                     tr_wr_i,
   input  logic [PAYLOAD_W-1:0]     tr_op_i,
   output logic [1:0]               take_o,
   output logic                     u_vld_o,
   output logic [PAYLOAD_W-1:0]     u_op_o,
   output logic                     v_vld_o,
   output logic [PAYLOAD_W-1:0]     v_op_o
);

   logic                 conflict;
   take_e                take;
   logic                 go_u, go_v;
   logic [PIPES-1:0]     go;
   logic [PAYLOAD_W-1:0] op_in  [PIPES];
   logic [PIPES-1:0]     vld;
   logic [PAYLOAD_W-1:0] op_out [PIPES];
   logic                 unused_simple;

   assign unused_simple = ld_simple_i;  // U accepts every class

   pair_hazard #(
      .REG_W(REG_W), .NUM_SRC(NUM_SRC), .CHECK_WAW(CHECK_WAW)
   ) u_hazard (
      .lead_dst (ld_dst_i),
      .lead_wr  (ld_wr_i),
      .trail_src(tr_src_i),
      .trail_dst(tr_dst_i),
      .trail_wr (tr_wr_i),
      .conflict (conflict)
   );

   pair_rules u_rules (
      .rst_n    (rst_n),
      .ready    (ready_i),
      .ld_vld   (ld_vld_i),
      .ld_both  (ld_both_i),
      .tr_vld   (tr_vld_i),
      .tr_simple(tr_simple_i),
      .tr_both  (tr_both_i),
      .conflict (conflict),
      .take     (take),
      .go_u     (go_u),
      .go_v     (go_v)
   );

   assign go[PIPE_U]    = go_u;
   assign go[PIPE_V]    = go_v;
   assign op_in[PIPE_U] = ld_op_i;
   assign op_in[PIPE_V] = tr_op_i;

   issue_stage #(.PAYLOAD_W(PAYLOAD_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .op_in (op_in),
      .vld   (vld),
      .op_out(op_out)
   );

   assign take_o  = take;
   assign u_vld_o = vld[PIPE_U];
   assign v_vld_o = vld[PIPE_V];
   assign u_op_o  = op_out[PIPE_U];
   assign v_op_o  = op_out[PIPE_V];

   // R2: a stalled downstream pops nothing and issues nothing next cycle
   a_r2_stall_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |-> (take_o == 2'd0));
   a_r2_stall_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |=> !u_vld_o);
   // R3: an accepted lead appears on U one cycle later
   a_r3_lead_to_u: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && ld_vld_i) |=> (u_vld_o && u_op_o == $past(ld_op_i)));
   // R4: a non-simple trail never pairs
   a_r4_v_simple_only: assert property (@(posedge clk) disable iff (!rst_n)
      !tr_simple_i |-> (take_o != 2'd2));
   // R5: a wide lead never pairs
   a_r5_wide_alone: assert property (@(posedge clk) disable iff (!rst_n)
      ld_both_i |-> (take_o != 2'd2));
   // R8: no reordering past an invalid lead
   a_r8_no_promote: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_vld_i |-> (take_o == 2'd0));
   // R9: a pair lands trail payload on V
   a_r9_pair_to_v: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o == 2'd2) |=> (v_vld_o && v_op_o == $past(tr_op_i)));
   // R10: take count is bounded
   a_r10_take_range: assert property (@(posedge clk) disable iff (!rst_n)
      take_o != 2'd3);

endmodule

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;

   localparam int CLK_PERIOD = 10;
   localparam int RW = 5;
   localparam int PW = 32;

   typedef struct packed {
      logic          rdy;
      logic          av, as, ab;
      logic [RW-1:0] as1, as2, ad;
      logic          aw;
      logic          bv, bs, bb;
      logic [RW-1:0] bs1, bs2, bd;
      logic          bw;
      logic [1:0]    cons;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      // R9 baseline pair
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd2},
      // R4 trail complex
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b0,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd1},
      // R5 lead needs both pipes
      '{1'b1, 1'b1,1'b0,1'b1, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd1},
      // R6 first trail source reads lead dst
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd3,5'd5,5'd6,1'b1, 2'd1},
      // R6 second trail source reads lead dst
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd3,5'd6,1'b1, 2'd1},
      // R7 trail writes lead dst
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd3,1'b1, 2'd1},
      // R7 lead does not write: matching indices are harmless
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b0, 1'b1,1'b1,1'b0, 5'd3,5'd3,5'd3,1'b1, 2'd2},
      // R2 ready low
      '{1'b0, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd0},
      // R8 lead invalid, trail valid
      '{1'b1, 1'b0,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd0},
      // R3 lead alone (trail invalid)
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b0,1'b1,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd1},
      // R3 complex lead still issues and pairs
      '{1'b1, 1'b1,1'b0,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd6,1'b1, 2'd2},
      // R7 trail dst matches but trail does not write
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b0, 5'd4,5'd5,5'd3,1'b0, 2'd2},
      // R4 trail needs both pipes
      '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b1,1'b1,1'b1, 5'd4,5'd5,5'd6,1'b1, 2'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ready_i = 1'b0;
   logic ld_vld_i = 1'b0, ld_simple_i = 1'b0, ld_both_i = 1'b0, ld_wr_i = 1'b0;
   logic tr_vld_i = 1'b0, tr_simple_i = 1'b0, tr_both_i = 1'b0, tr_wr_i = 1'b0;
   logic [2*RW-1:0] ld_src_i = '0, tr_src_i = '0;
   logic [RW-1:0] ld_dst_i = '0, tr_dst_i = '0;
   logic [PW-1:0] ld_op_i = '0, tr_op_i = '0;
   logic [1:0] take_o;
   logic u_vld_o, v_vld_o;
   logic [PW-1:0] u_op_o, v_op_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_issue_pair u0 (
      .clk(clk), .rst_n(rst_n), .ready_i(ready_i),
      .ld_vld_i(ld_vld_i), .ld_simple_i(ld_simple_i), .ld_both_i(ld_both_i),
      .ld_src_i(ld_src_i), .ld_dst_i(ld_dst_i), .ld_wr_i(ld_wr_i), .ld_op_i(ld_op_i),
      .tr_vld_i(tr_vld_i), .tr_simple_i(tr_simple_i), .tr_both_i(tr_both_i),
      .tr_src_i(tr_src_i), .tr_dst_i(tr_dst_i), .tr_wr_i(tr_wr_i), .tr_op_i(tr_op_i),
      .take_o(take_o), .u_vld_o(u_vld_o), .u_op_o(u_op_o),
      .v_vld_o(v_vld_o), .v_op_o(v_op_o)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v, input logic [PW-1:0] aop,
                        input logic [PW-1:0] bop);
      ready_i = v.rdy;
      ld_vld_i = v.av; ld_simple_i = v.as; ld_both_i = v.ab;
      ld_src_i = {v.as2, v.as1}; ld_dst_i = v.ad; ld_wr_i = v.aw; ld_op_i = aop;
      tr_vld_i = v.bv; tr_simple_i = v.bs; tr_both_i = v.bb;
      tr_src_i = {v.bs2, v.bs1}; tr_dst_i = v.bd; tr_wr_i = v.bw; tr_op_i = bop;
   endtask

   // in-order queue model for the ordering test
   localparam int QN = 4;
   vec_t q [QN];

   initial begin
      #(CLK_PERIOD*100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: reset holds everything idle even with a valid pair offered
      @(negedge clk);
      apply(VECS[0], 32'h11, 32'h22);
      #1;
      chk("R1", "take in reset", take_o, 0);
      @(posedge clk); #1;
      chk("R1", "u_vld in reset", u_vld_o, 0);
      chk("R1", "v_vld in reset", v_vld_o, 0);
      @(negedge clk);
      ld_vld_i = 1'b0; tr_vld_i = 1'b0; ready_i = 1'b1;
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R1", "take idle", take_o, 0);
         @(posedge clk); #1;
         chk("R1", "u_vld idle", u_vld_o, 0);
         chk("R1", "v_vld idle", v_vld_o, 0);
         @(negedge clk);
      end

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [PW-1:0] aop, bop;
         aop = 32'hA000 + i;
         bop = 32'hB000 + i;
         apply(VECS[i], aop, bop);
         #1;
         chk($sformatf("R%0d", 0) == "" ? "" : $sformatf("vec%0d", i),
             "take", take_o, VECS[i].cons);
         @(posedge clk); #1;
         chk($sformatf("vec%0d", i), "u_vld", u_vld_o, VECS[i].cons != 0);
         chk($sformatf("vec%0d", i), "v_vld", v_vld_o, VECS[i].cons == 2);
         if (VECS[i].cons != 0) chk($sformatf("vec%0d R3", i), "u_op", u_op_o, aop);
         if (VECS[i].cons == 2) chk($sformatf("vec%0d R9", i), "v_op", v_op_o, bop);
         @(negedge clk);
      end

      // R8 ordering: a refused trail becomes the next lead, never overtaken
      q[0] = '{1'b1, 1'b1,1'b1,1'b0, 5'd1,5'd2,5'd3,1'b1, 1'b0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0, 2'd0};
      q[1] = '{1'b1, 1'b1,1'b1,1'b0, 5'd3,5'd4,5'd7,1'b1, 1'b0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0, 2'd0};
      q[2] = '{1'b1, 1'b1,1'b1,1'b0, 5'd8,5'd9,5'd10,1'b1, 1'b0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0, 2'd0};
      q[3] = '{1'b1, 1'b1,1'b0,1'b0, 5'd1,5'd1,5'd11,1'b1, 1'b0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0, 2'd0};
      begin
         int head;
         int exp_take [3] = '{1, 2, 1};
         head = 0;
         for (int s = 0; s < 3; s++) begin
            vec_t v;
            v = q[head];
            if (head + 1 < QN) begin
               v.bv = 1'b1; v.bs = q[head+1].as; v.bb = q[head+1].ab;
               v.bs1 = q[head+1].as1; v.bs2 = q[head+1].as2;
               v.bd = q[head+1].ad; v.bw = q[head+1].aw;
            end
            apply(v, 32'hC000 + head, 32'hC000 + head + 1);
            #1;
            chk("R8 order", "take", take_o, exp_take[s]);
            @(posedge clk); #1;
            chk("R8 order", "u_op", u_op_o, 32'hC000 + head);
            if (exp_take[s] == 2) chk("R9 order", "v_op", v_op_o, 32'hC000 + head + 1);
            head += exp_take[s];
            @(negedge clk);
         end
         chk("R8 order", "head", head, 4);
      end

      // R2: issue stops one cycle after ready drops
      apply(VECS[0], 32'h1, 32'h2);
      ready_i = 1'b0;
      @(posedge clk); #1;
      chk("R2", "u_vld after stall", u_vld_o, 0);
      chk("R2", "v_vld after stall", v_vld_o, 0);
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule